// File: doc/BRIEF.md
# Sequential Non-Restoring Single-Precision Divider

This block divides one single-precision floating-point number by another. Each operand arrives as a sign bit, an 8-bit biased exponent and a 23-bit fraction with an implied leading one. The block works iteratively. A start pulse captures both operands. A 32-step non-restoring loop then produces one quotient bit per clock. The sign of each partial remainder picks the next operation (subtract while non-negative, add while negative) and also gives the quotient bit, which is the inverse of that sign.

One extra cycle normalizes the quotient, so that its leading one sits at the implied-bit position and the exponent is corrected by the same shift. The result is then driven on the outputs together with a single-cycle done pulse. Results are truncated, with no rounding and no guard bits. Infinities, NaNs, denormals and exponent overflow or underflow are not treated specially. The one exception is a divisor whose exponent and fraction are both zero, which yields an all-zero result.

Top module: `fdiv_nonrestore`

## Requirements
- R1: The result sign equals the XOR of the two operand signs, unless the divisor is zero (R8).
- R2: The result exponent is dividendExp - divisorExp + 127 when the dividend mantissa (1.fraction) is not smaller than the divisor mantissa, and one less than that otherwise.
- R3: The result fraction is the low 23 bits of floor(Ma * 2^23 / Mb) when Ma >= Mb, and of floor(Ma * 2^24 / Mb) otherwise. Here Ma and Mb are the 24-bit mantissas with the hidden one. The quotient is truncated, never rounded.
- R4: Packing a value as the word {sign, exponent, fraction} (bit 31 sign, bits 30:23 exponent, bits 22:0 fraction), the operands 0x19FF0000 / 0x18010000 give 0x417D05F4.
- R5: A start that arrives while busy is high is ignored. It does not change the result in progress, and every accepted start yields exactly one done pulse.
- R6: busy rises after the clock edge that accepts start and stays high for exactly 33 cycles (32 iterations plus one normalize cycle). done and the result appear on the 33rd edge after the accepting edge.
- R7: done is high for exactly one cycle. The result outputs hold their value, whatever the inputs do, until the next result is written.
- R8: A divisor with zero exponent and zero fraction gives sign 0, exponent 0 and fraction 0, with the same timing as any other division.
- R9: After reset, busy, done and all result outputs are zero.
- R10: The extreme mantissa ratios are normalized correctly. These are a dividend fraction of all ones over a divisor fraction of zero (ratio just under 2), and a dividend fraction of zero over a divisor fraction of all ones (ratio just over 1/2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division; sampled only while idle |
| aSign | input | 1 | Dividend sign |
| aExp | input | 8 | Dividend biased exponent |
| aFrac | input | 23 | Dividend fraction |
| bSign | input | 1 | Divisor sign |
| bExp | input | 8 | Divisor biased exponent |
| bFrac | input | 23 | Divisor fraction |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle pulse when the result is written |
| qSign | output | 1 | Quotient sign |
| qExp | output | 8 | Quotient biased exponent |
| qFrac | output | 23 | Quotient fraction (truncated) |

## Verification
The remainder-bound property relies on both captured mantissas carrying the hidden one. Under that condition the initial partial remainder (half the dividend mantissa) is always below the divisor, and every later remainder stays within plus or minus the divisor.

The timing properties assume that start is the only control input, and that operands matter only on the edge that accepts start. The stimulus therefore changes operands and raises start during busy freely, to show that neither has an effect. It keeps operand exponents in a mid range, so that the result exponent never wraps.

Reference results are computed in the bench from R2 and R3 using wide integer division. They are queued at each accepted start and compared when done fires.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // capture operands, seed remainder
    logic step;     // one non-restoring iteration
    logic keepBit;  // record this iteration's quotient bit
    logic finish;   // normalize and write the result
  } divStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } divState_t;

endpackage

// File: rtl/fdiv_ctrl.sv
module fdiv_ctrl
  import fdiv_pkg::*;
#(
  parameter int ITERS = 32,
  parameter int QW    = 25
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output divStrobes_t stb,
  output logic        busy,
  output logic        done
);

  localparam int CW = $clog2(ITERS);
  localparam int LW = $clog2(ITERS + 2);
  localparam logic [CW-1:0] LAST = CW'(ITERS - 1);

  divState_t       state;
  logic [CW-1:0]   cnt;

  always_comb begin
    busy        = (state != ST_IDLE);
    stb.load    = (state == ST_IDLE) && start;
    stb.step    = (state == ST_RUN);
    stb.keepBit = (state == ST_RUN) && (int'(cnt) < QW);
    stb.finish  = (state == ST_FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= (state == ST_FIN);
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          cnt   <= '0;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker counter: length of the latest busy window
  logic [LW-1:0] chkLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         chkLen <= '0;
    else if (stb.load) chkLen <= '0;
    else if (busy)     chkLen <= chkLen + 1'b1;
  end

  // R5: a start seen mid-run does not restart the iteration count
  p_ignore_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && start && cnt != LAST) |=> (state == ST_RUN && cnt == $past(cnt) + 1'b1));

  // R6: each result follows a busy window of ITERS+1 cycles
  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (chkLen == LW'(ITERS + 1)));

  // R7: done never lasts two cycles
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/fdiv_dpath.sv
module fdiv_dpath
  import fdiv_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int ITERS  = 32,
  parameter int QW     = FRAC_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  divStrobes_t       stb,
  input  logic              aSign,
  input  logic [EXP_W-1:0]  aExp,
  input  logic [FRAC_W-1:0] aFrac,
  input  logic              bSign,
  input  logic [EXP_W-1:0]  bExp,
  input  logic [FRAC_W-1:0] bFrac,
  output logic              qSign,
  output logic [EXP_W-1:0]  qExp,
  output logic [FRAC_W-1:0] qFrac
);

  localparam int MW    = FRAC_W + 1;
  localparam int REM_W = ITERS;
  localparam logic [EXP_W-1:0] BIAS = EXP_W'((1 << (EXP_W - 1)) - 1);

  logic [MW-1:0]    aMant, bMant, divR;
  logic [REM_W-1:0] remR, remShift, remNext, divExt;
  logic [ITERS-1:0] streamR;
  logic [QW-1:0]    quoR;
  logic [EXP_W-1:0] expRaw;
  logic             signR, zeroDivR;

  always_comb begin
    aMant    = {1'b1, aFrac};
    bMant    = {1'b1, bFrac};
    divExt   = {{(REM_W - MW){1'b0}}, divR};
    remShift = {remR[REM_W-2:0], streamR[ITERS-1]};
    remNext  = remR[REM_W-1] ? (remShift + divExt) : (remShift - divExt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR     <= '0;
      streamR  <= '0;
      divR     <= '0;
      quoR     <= '0;
      expRaw   <= '0;
      signR    <= 1'b0;
      zeroDivR <= 1'b0;
      qSign    <= 1'b0;
      qExp     <= '0;
      qFrac    <= '0;
    end else begin
      if (stb.load) begin
        // dividend scaled by 2^(ITERS-1): high part seeds the remainder
        remR     <= {{(REM_W - MW + 1){1'b0}}, aMant[MW-1:1]};
        streamR  <= {aMant[0], {(ITERS - 1){1'b0}}};
        divR     <= bMant;
        quoR     <= '0;
        expRaw   <= aExp - bExp + BIAS;
        signR    <= aSign ^ bSign;
        zeroDivR <= (bExp == '0) && (bFrac == '0);
      end
      if (stb.step) begin
        remR    <= remNext;
        streamR <= {streamR[ITERS-2:0], 1'b0};
        if (stb.keepBit) quoR <= {quoR[QW-2:0], ~remNext[REM_W-1]};
      end
      if (stb.finish) begin
        if (zeroDivR) begin
          qSign <= 1'b0;
          qExp  <= '0;
          qFrac <= '0;
        end else begin
          qSign <= signR;
          if (quoR[QW-1]) begin
            qExp  <= expRaw;
            qFrac <= quoR[QW-2 -: FRAC_W];
          end else begin
            qExp  <= expRaw - 1'b1;
            qFrac <= quoR[QW-3 -: FRAC_W];
          end
        end
      end
    end
  end

  // R3: the partial remainder stays within +/- divisor throughout the loop
  p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |-> (($signed(remR) < $signed(divExt)) && ($signed(remR) >= -$signed(divExt))));

  // R7: outputs change only on a finish cycle
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.finish |=> $stable({qSign, qExp, qFrac}));

  // R8: zero divisor yields an all-zero result
  p_zero_div_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.finish && zeroDivR) |=> (!qSign && qExp == '0 && qFrac == '0));

endmodule

// File: rtl/fdiv_nonrestore.sv
module fdiv_nonrestore
  import fdiv_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int ITERS  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              aSign,
  input  logic [EXP_W-1:0]  aExp,
  input  logic [FRAC_W-1:0] aFrac,
  input  logic              bSign,
  input  logic [EXP_W-1:0]  bExp,
  input  logic [FRAC_W-1:0] bFrac,
  output logic              busy,
  output logic              done,
  output logic              qSign,
  output logic [EXP_W-1:0]  qExp,
  output logic [FRAC_W-1:0] qFrac
);

  localparam int QW = FRAC_W + 2;

  divStrobes_t stb;

  fdiv_ctrl #(.ITERS(ITERS), .QW(QW)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stb   (stb),
    .busy  (busy),
    .done  (done)
  );

  fdiv_dpath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .ITERS(ITERS), .QW(QW)) uDpath (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .aSign (aSign),
    .aExp  (aExp),
    .aFrac (aFrac),
    .bSign (bSign),
    .bExp  (bExp),
    .bFrac (bFrac),
    .qSign (qSign),
    .qExp  (qExp),
    .qFrac (qFrac)
  );

endmodule

// File: tb/sim_fdiv_nonrestore.sv
`timescale 1ns/1ps
module sim_fdiv_nonrestore;

  localparam int ITERS = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        aSign = 1'b0, bSign = 1'b0;
  logic [7:0]  aExp = '0, bExp = '0;
  logic [22:0] aFrac = '0, bFrac = '0;
  logic        busy, done, qSign;
  logic [7:0]  qExp;
  logic [22:0] qFrac;

  fdiv_nonrestore u0 (
    .clk(clk), .rstN(rstN), .start(start),
    .aSign(aSign), .aExp(aExp), .aFrac(aFrac),
    .bSign(bSign), .bExp(bExp), .bFrac(bFrac),
    .busy(busy), .done(done),
    .qSign(qSign), .qExp(qExp), .qFrac(qFrac)
  );

  always #4 clk = ~clk;  // 125 MHz

  int     checks = 0;
  int     fails  = 0;
  longint cyc    = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] expQ[$];
  string       tagQ[$];
  longint      edgeQ[$];

  task automatic check(input string tag, input longint act, input longint expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Reference model built from R2, R3, R8
  function automatic logic [31:0] refDiv(input logic [31:0] a, input logic [31:0] b);
    longint ma, mb, m;
    int     e;
    if (b[30:0] == 31'd0) return 32'd0;
    ma = longint'({1'b1, a[22:0]});
    mb = longint'({1'b1, b[22:0]});
    e  = int'(a[30:23]) - int'(b[30:23]) + 127;
    if (ma >= mb) m = (ma << 23) / mb;
    else begin
      m = (ma << 24) / mb;
      e = e - 1;
    end
    return {a[31] ^ b[31], e[7:0], m[22:0]};
  endfunction

  // Monitor / scoreboard
  int          busyRun = 0;
  bit          lastDone = 1'b0;
  logic [31:0] eItem;
  string       tItem;
  longint      sItem;
  always @(negedge clk) begin
    if (rstN) begin
      if (lastDone) check("R7 done width", done, 0);
      lastDone = done;
      if (busy) busyRun++;
      if (done) begin
        if (expQ.size() == 0) check("R5 unexpected done", 1, 0);
        else begin
          eItem = expQ.pop_front();
          tItem = tagQ.pop_front();
          sItem = edgeQ.pop_front();
          check(tItem, {qSign, qExp, qFrac}, eItem);
          check("R6 start-to-done edges", cyc - sItem, ITERS + 1);
          check("R6 busy length", busyRun, ITERS + 1);
        end
        busyRun = 0;
      end
    end
  end

  // Driver
  task automatic runOp(input logic [31:0] a, input logic [31:0] b,
                       input string tag, input bit poke);
    while (expQ.size() != 0 || busy) @(negedge clk);
    {aSign, aExp, aFrac} = a;
    {bSign, bExp, bFrac} = b;
    start = 1'b1;
    expQ.push_back(refDiv(a, b));
    tagQ.push_back(tag);
    edgeQ.push_back(cyc + 1);
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (9) @(negedge clk);
      {aSign, aExp, aFrac} = b;          // R5: new operands and start mid-run
      {bSign, bExp, bFrac} = 32'h3F80_0001;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  task automatic drain();
    while (expQ.size() != 0 || busy || done) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check("R9 busy at reset", busy, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 busy after reset", busy, 0);
    check("R9 done after reset", done, 0);
    check("R9 result after reset", {qSign, qExp, qFrac}, 0);

    runOp(32'h19FF_0000, 32'h1801_0000, "R4 reference pair", 1'b0);
    runOp(32'h3F80_0000, 32'h3F80_0000, "R2 equal mantissas", 1'b0);
    runOp(32'hBFC0_0000, 32'h3FC0_0000, "R1 negative by positive", 1'b0);
    runOp(32'hC0E0_0000, 32'hC040_0000, "R1 negative by negative", 1'b0);
    runOp(32'h3F80_0000, 32'h3FC0_0000, "R2 ratio below one", 1'b0);
    runOp(32'h3F80_0000, 32'h4040_0000, "R3 truncated one third", 1'b0);
    runOp(32'h407F_FFFF, 32'h3F80_0000, "R10 ratio near two", 1'b0);
    runOp(32'h3F80_0000, 32'h3FFF_FFFF, "R10 ratio near half", 1'b0);
    runOp(32'h4120_0000, 32'h0000_0000, "R8 zero divisor", 1'b0);
    runOp(32'hC120_0000, 32'h8000_0000, "R8 negative zero divisor", 1'b0);
    runOp(32'h19FF_0000, 32'h1801_0000, "R5 start during busy", 1'b1);

    for (int i = 0; i < 24; i++) begin
      logic [31:0] a, b;
      a = {$urandom_range(1, 0) == 1, 8'(100 + $urandom_range(49, 0)), 23'($urandom)};
      b = {$urandom_range(1, 0) == 1, 8'(100 + $urandom_range(49, 0)), 23'($urandom)};
      runOp(a, b, "R3 mixed operands", (i % 4) == 0);
    end

    drain();
    held = {qSign, qExp, qFrac};
    {aSign, aExp, aFrac} = 32'h4000_0000;
    {bSign, bExp, bFrac} = 32'h3F00_0000;
    repeat (6) @(negedge clk);
    check("R7 result holds", {qSign, qExp, qFrac}, held);
    check("R5 no pending results", expQ.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule